// File: doc/BRIEF.md
# Signed Packed-Decimal Subtractor

This block subtracts one signed packed-decimal number from another and returns the signed packed-decimal difference together with a four-bit condition code. Each operand and the result carry a sign nibble in bits 3:0. Above it sit DIGITS decimal digits, four bits each, with the least significant digit in bits 7:4. With the default of 31 digits the word is 128 bits wide. The block sorts the two magnitudes and subtracts the smaller from the larger. When the signs differ it adds the magnitudes instead. It then builds the result sign and the condition code from the sign and size of the exact difference.

Operands enter through a valid/ready handshake. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The result is registered on that same edge, so it is presented one cycle later with `out_valid` high. While `out_valid` is high and `out_ready` is low, the result is held and `in_ready` is low, which stalls the producer. When `out_ready` is high the output register drains, and a new operation may enter in that same cycle. The positive-sign selection `pos_sel` is a plain control pin that is sampled together with the operands.

Top module: `bcd_signed_sub`

## Requirements
- R1: Sign nibbles 0xA, 0xC, 0xE and 0xF mean positive, and 0xB and 0xD mean negative. Any operand sign code from this set is treated by that meaning.
- R2: If a digit of either operand is above 9, or a sign nibble is 0x0 to 0x9, then flags_o is 4'b0001. The result value is unspecified in that case.
- R3: A negative nonzero difference gives sign nibble 0xD and sets LT (flags_o bit 3) as its only comparison flag.
- R4: A positive nonzero difference sets GT (flags_o bit 2). Its sign nibble is 0xF when pos_sel is 1 and 0xC when pos_sel is 0.
- R5: An exactly zero difference gives flags_o = 4'b0010 (EQ, bit 1). Its sign is positive and follows pos_sel, including for negative zero minus positive zero.
- R6: If the magnitude of the exact difference needs more than DIGITS digits, SO (flags_o bit 0) is set together with LT or GT. The result keeps only the low DIGITS digits, and the sign is that of the exact difference.
- R7: For valid operands, the digit field of res_o is the decimal magnitude of opa_i minus opb_i, and every result digit is in the range 0 to 9.
- R8: An operation accepted on an edge, with in_valid and in_ready both high, is presented with out_valid high right after that edge. in_ready is high exactly when out_valid is low or out_ready is high.
- R9: While out_valid is high and out_ready is low, out_valid, res_o and flags_o stay unchanged.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Block can accept operands |
| opa_i | input | 4*DIGITS+4 | Minuend, packed decimal with sign nibble |
| opb_i | input | 4*DIGITS+4 | Subtrahend, packed decimal with sign nibble |
| pos_sel | input | 1 | Positive sign code select: 1 gives 0xF, 0 gives 0xC |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_o | output | 4*DIGITS+4 | Difference, packed decimal with sign nibble |
| flags_o | output | 4 | LT, GT, EQ, SO in bits 3 to 0 |

## Verification
The bench goes after these corners:
- **Overflow that truncates to zero** (largest positive minus negative one, and its negative mirror). A design that tested for zero on the truncated magnitude would report EQ instead of GT or LT with SO.
- **Equal magnitudes with equal signs, and a negative zero against a positive zero.** Here a wrong sign rule would emit 0xD or set LT.
- **Operands of mixed length with borrows that run across many digits.** These expose a missing ten's correction or a swapped operand order as wrong digits.
- **Invalid digits and invalid sign codes.** A design that ignored them would return arithmetic flags instead of the lone SO.
- **Random stalls on the output.** A result that changes while it is held is caught.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;
  localparam int FLAG_LT = 3;
  localparam int FLAG_GT = 2;
  localparam int FLAG_EQ = 1;
  localparam int FLAG_SO = 0;

  localparam logic [3:0] SGN_NEG      = 4'hD;
  localparam logic [3:0] SGN_POS_ALT  = 4'hF;
  localparam logic [3:0] SGN_POS_STD  = 4'hC;
  localparam logic [3:0] FLAGS_BAD    = 4'b0001;

  typedef enum logic [1:0] {SC_POS, SC_NEG, SC_BAD} sign_class_e;

  function automatic sign_class_e classify_sign(input logic [3:0] nib);
    case (nib)
      4'hA, 4'hC, 4'hE, 4'hF: return SC_POS;
      4'hB, 4'hD:             return SC_NEG;
      default:                return SC_BAD;
    endcase
  endfunction
endpackage

// File: rtl/bcd_operand_check.sv
module bcd_operand_check
  import bcd_sub_pkg::*;
#(
  parameter int DIGITS = 31,
  localparam int MW = 4 * DIGITS,
  localparam int W  = MW + 4
) (
  input  logic [W-1:0]  opnd,
  output logic          ok_o,
  output logic          neg_o,
  output logic [MW-1:0] mag_o
);
  logic [DIGITS-1:0] dig_ok;
  sign_class_e       cls;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign dig_ok[i] = (opnd[4*i+4 +: 4] <= 4'd9);
  end

  assign cls   = classify_sign(opnd[3:0]);
  assign ok_o  = (&dig_ok) && (cls != SC_BAD);
  assign neg_o = (cls == SC_NEG);
  assign mag_o = opnd[W-1:4];
endmodule

// File: rtl/bcd_mag_compare.sv
module bcd_mag_compare #(
  parameter int DIGITS = 31,
  localparam int MW = 4 * DIGITS
) (
  input  logic [MW-1:0] a,
  input  logic [MW-1:0] b,
  output logic          a_gt_b,
  output logic          a_eq_b
);
  // Valid packed-decimal digits order the same way as binary weights,
  // so a plain unsigned compare ranks decimal magnitudes.
  assign a_gt_b = (a > b);
  assign a_eq_b = (a == b);
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain #(
  parameter int DIGITS = 31,
  localparam int MW = 4 * DIGITS
) (
  input  logic          sub,
  input  logic [MW-1:0] x,
  input  logic [MW-1:0] y,
  output logic [MW-1:0] z,
  output logic          c_out
);
  logic [DIGITS:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [4:0] xa, yb, sum, dif;
    logic       fix;
    assign xa  = {1'b0, x[4*i +: 4]};
    assign yb  = {1'b0, y[4*i +: 4]};
    assign sum = xa + yb + {4'd0, c[i]};
    assign dif = xa - yb - {4'd0, c[i]};
    assign fix = sub ? dif[4] : (sum > 5'd9);
    assign z[4*i +: 4] = sub ? (dif[3:0] + (fix ? 4'd10 : 4'd0))
                             : (sum[3:0] - (fix ? 4'd10 : 4'd0));
    assign c[i+1] = fix;
  end

  assign c_out = c[DIGITS];
endmodule

// File: rtl/bcd_signed_sub.sv
module bcd_signed_sub
  import bcd_sub_pkg::*;
#(
  parameter int DIGITS = 31,
  localparam int MW = 4 * DIGITS,
  localparam int W  = MW + 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         pos_sel,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] res_o,
  output logic [3:0]   flags_o
);
  logic          a_ok, b_ok, a_neg, b_neg;
  logic [MW-1:0] mag_a, mag_b, x_sel, y_sel, mag_z;
  logic          a_gt_b, a_eq_b, eff_sub, swap, chain_c;
  logic          is_zero, is_neg, is_ovf, all_ok;
  logic [W-1:0]  res_d;
  logic [3:0]    flags_d;
  logic          accept;

  bcd_operand_check #(.DIGITS(DIGITS)) u_chk_a (
    .opnd(opa_i), .ok_o(a_ok), .neg_o(a_neg), .mag_o(mag_a));
  bcd_operand_check #(.DIGITS(DIGITS)) u_chk_b (
    .opnd(opb_i), .ok_o(b_ok), .neg_o(b_neg), .mag_o(mag_b));

  bcd_mag_compare #(.DIGITS(DIGITS)) u_cmp (
    .a(mag_a), .b(mag_b), .a_gt_b(a_gt_b), .a_eq_b(a_eq_b));

  // Equal signs: magnitudes subtract (larger minus smaller).
  // Different signs: magnitudes add, sign follows the minuend.
  assign eff_sub = (a_neg == b_neg);
  assign swap    = eff_sub && !a_gt_b;
  assign x_sel   = swap ? mag_b : mag_a;
  assign y_sel   = swap ? mag_a : mag_b;

  bcd_digit_chain #(.DIGITS(DIGITS)) u_chain (
    .sub(eff_sub), .x(x_sel), .y(y_sel), .z(mag_z), .c_out(chain_c));

  always_comb begin
    all_ok  = a_ok && b_ok;
    is_ovf  = !eff_sub && chain_c;
    is_zero = eff_sub ? a_eq_b : ((mag_z == '0) && !chain_c);
    if (is_zero)      is_neg = 1'b0;
    else if (eff_sub) is_neg = a_gt_b ? a_neg : !a_neg;
    else              is_neg = a_neg;

    if (!all_ok) begin
      res_d   = '0;
      flags_d = FLAGS_BAD;
    end else begin
      res_d   = {mag_z, is_neg ? SGN_NEG : (pos_sel ? SGN_POS_ALT : SGN_POS_STD)};
      flags_d = '0;
      flags_d[FLAG_LT] = is_neg;
      flags_d[FLAG_GT] = !is_neg && !is_zero;
      flags_d[FLAG_EQ] = is_zero;
      flags_d[FLAG_SO] = is_ovf;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_o     <= '0;
      flags_o   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_o     <= res_d;
      flags_o   <= flags_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Digit range of the registered result, used by the checks below.
  logic [DIGITS-1:0] res_dig_ok;
  for (genvar i = 0; i < DIGITS; i++) begin : g_rchk
    assign res_dig_ok[i] = (res_o[4*i+4 +: 4] <= 4'd9);
  end

  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_o) && $stable(flags_o));

  assert_single_cmp_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags_o != FLAGS_BAD |-> $countones(flags_o[3:1]) == 1);

  assert_neg_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags_o[FLAG_LT] |-> res_o[3:0] == SGN_NEG);

  assert_zero_no_so_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags_o[FLAG_EQ] |-> !flags_o[FLAG_SO] && res_o[3:0] != SGN_NEG);

  assert_digit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags_o != FLAGS_BAD |-> &res_dig_ok);
endmodule

// File: tb/sim_bcd_signed_sub.sv
module sim_bcd_signed_sub;
  localparam int CLK_PERIOD = 10;
  localparam int DIGITS = 31;
  localparam int MW = 4 * DIGITS;
  localparam int W  = MW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, pos_sel = 1'b0, out_valid, out_ready = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, res;
  logic [3:0] flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_signed_sub #(.DIGITS(DIGITS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa_i(opa), .opb_i(opb), .pos_sel(pos_sel), .out_valid(out_valid),
    .out_ready(out_ready), .res_o(res), .flags_o(flags));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [139:0] to_bin(input logic [MW-1:0] m);
    logic signed [139:0] v = 0;
    for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + 140'(m[4*i +: 4]);
    return v;
  endfunction

  function automatic logic [MW-1:0] to_bcd(input logic signed [139:0] v);
    logic [MW-1:0] m = '0;
    logic signed [139:0] t = v;
    for (int i = 0; i < DIGITS; i++) begin
      m[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return m;
  endfunction

  function automatic int sgn_cls(input logic [3:0] n); // 0 pos, 1 neg, 2 bad
    if (n == 4'hA || n == 4'hC || n == 4'hE || n == 4'hF) return 0;
    if (n == 4'hB || n == 4'hD) return 1;
    return 2;
  endfunction

  function automatic bit opnd_ok(input logic [W-1:0] o);
    if (sgn_cls(o[3:0]) == 2) return 1'b0;
    for (int i = 0; i < DIGITS; i++) if (o[4*i+4 +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic signed [139:0] ten_pow();
    logic signed [139:0] p = 1;
    for (int i = 0; i < DIGITS; i++) p = p * 10;
    return p;
  endfunction

  function automatic logic [W-1:0] rand_opnd();
    logic [W-1:0] o = '0;
    int n = $urandom_range(0, DIGITS);
    bit nines = ($urandom_range(0, 7) == 0);
    logic [3:0] codes [6] = '{4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
    for (int i = 0; i < DIGITS; i++)
      if (nines || i < n) o[4*i+4 +: 4] = nines ? 4'd9 : 4'($urandom_range(0, 9));
    o[3:0] = codes[$urandom_range(0, 5)];
    if ($urandom_range(0, 11) == 0) begin
      if ($urandom_range(0, 1) == 0) o[3:0] = 4'($urandom_range(0, 9));
      else o[4*$urandom_range(0, DIGITS-1)+4 +: 4] = 4'($urandom_range(10, 15));
    end
    return o;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
    logic [W-1:0] exp_res;
    logic [3:0] exp_fl;
    string tag;
    bit bad;
    logic signed [139:0] va, vb, r, mag, pw;
    logic [W-1:0] held_res;
    logic [3:0] held_fl;
    int stall;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready when idle", W'(in_ready), W'(1));
    opa = a; opb = b; pos_sel = p; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8 result valid one cycle after accept", W'(out_valid), W'(1));

    bad = !(opnd_ok(a) && opnd_ok(b));
    exp_res = '0;
    if (bad) begin
      exp_fl = 4'b0001; tag = "R2";
    end else begin
      pw  = ten_pow();
      va  = to_bin(a[W-1:4]); if (sgn_cls(a[3:0]) == 1) va = -va;
      vb  = to_bin(b[W-1:4]); if (sgn_cls(b[3:0]) == 1) vb = -vb;
      r   = va - vb;
      mag = (r < 0) ? -r : r;
      exp_fl = {r < 0, r > 0, r == 0, mag >= pw};
      exp_res = {to_bcd(mag % pw), (r < 0) ? 4'hD : (p ? 4'hF : 4'hC)};
      if (mag >= pw) tag = "R6";
      else if (r == 0) tag = "R5";
      else if (r < 0) tag = "R3";
      else tag = "R4";
    end
    chk(flags == exp_fl, {tag, " flags"}, W'(flags), W'(exp_fl));
    if (!bad) chk(res == exp_res, {tag, " R7 result"}, res, exp_res);

    held_res = res; held_fl = flags;
    stall = $urandom_range(0, 2);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(out_valid && res == held_res && flags == held_fl, "R9 hold under stall",
          res, held_res);
      chk(in_ready == 1'b0, "R8 not ready while stalled", W'(in_ready), W'(0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R8 drained", W'(out_valid), W'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] max_pos, max_neg, nine8, one_p, one_n, zero_p, zero_n;
    void'($urandom(32'd20240611));
    max_pos = {{DIGITS{4'h9}}, 4'hC};
    max_neg = {{DIGITS{4'h9}}, 4'hD};
    nine8   = {{(DIGITS-1){4'h9}}, 4'h8, 4'hC};
    one_p   = W'(8'h1C);
    one_n   = W'(8'h1D);
    zero_p  = W'(4'hC);
    zero_n  = W'(4'hD);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid in reset", W'(out_valid), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 idle after reset",
        W'({out_valid, in_ready}), W'(2'b01));

    run_op(max_pos, max_pos, 1'b0);            // R5 zero, 0xC
    run_op(max_pos, max_pos, 1'b1);            // R5 zero, 0xF
    run_op(max_pos, one_n, 1'b0);              // R6 truncates to zero, GT|SO
    run_op(max_pos, one_n, 1'b1);              // R6
    run_op(nine8, one_n, 1'b1);                // R4 no overflow
    run_op(zero_p, one_p, 1'b0);               // R3 -1
    run_op(max_neg, one_p, 1'b1);              // R6 LT|SO
    run_op(zero_n, zero_p, 1'b1);              // R5 negative zero minus zero
    run_op(one_p, W'(16'hF00), 1'b0);          // R2 bad digit
    run_op(W'(16'hBAD), W'(16'hF00), 1'b1);    // R2 bad sign and digit
    run_op(W'(12'h250), one_p, 1'b0);          // R2 sign 0x0
    run_op(W'(12'h73A), W'(12'h25E), 1'b1);    // R1 alt positive codes
    run_op(W'(12'h73B), W'(12'h25A), 1'b0);    // R1 alt negative code
    run_op(W'(20'h1000C), W'(8'h1C), 1'b0);    // R7 long borrow chain
    for (int n = 0; n < 500; n++) run_op(rand_opnd(), rand_opnd(), 1'($urandom_range(0, 1)));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule